// File: doc/BRIEF.md
# Full-Duplex Serial Slot to Shared Parallel Converter Bridge

The bridge connects a host's synchronous serial port to a converter pair: a DAC and an ADC that share one 16-bit parallel bus. On the serial side, 16-bit slots run back to back. Every bit clock carries a bit, and there are no idle clocks between slots. In each slot the host shifts one DAC word in and receives one ADC result. At a 48 MHz bit clock this gives 3 MSPS in each direction.

On the parallel side, each slot goes through a fixed sequence, timed by the slot bit counter:

1. The bridge drives the bus with the DAC code received in the previous slot and strobes the DAC.
2. It releases the bus for a turnaround gap.
3. It strobes the ADC and captures the value on the bus.

The captured ADC value is shifted out to the host in the next slot. ADC results therefore reach the host one slot after they are read.

The bus is modelled as separate drive, enable and sample vectors. A pad-level tristate combines them outside this block. `clk_i` is the bit clock. Inputs are sampled and state advances on its rising edge.

Top module: `ssp_pbus_bridge`

## Requirements
- R1: While `rst_ni` is low, `sd_o`, `bus_oe_o`, `dac_wr_o` and `adc_rd_o` are 0 and `bus_d_o` is 0. Reset also clears all shift, hold and capture state.
- R2: Until the first clock with `fs_i` high after reset, all outputs stay 0, whatever `sd_i` and `bus_d_i` carry.
- R3: `fs_i` is high in the clock before bit 15 of a slot. After the first such pulse, slots of 16 clocks follow each other without further pulses. A pulse arriving in the last clock of a slot is consistent with the running count.
- R4: Serial data is MSB first. The DAC code is received bits 15..2; bits 1..0 are ignored. While driving, the bus carries the code on `bus_d_o[13:0]`, and `bus_d_o[15:14]` is 0.
- R5: A DAC word received in slot n is written in slot n+1. `bus_oe_o` is high during bit times 15, 14 and 13, and `dac_wr_o` is high during bit time 14 only. No write happens before the first complete word.
- R6: Outside the drive window, `bus_oe_o` is 0 and `bus_d_o` is 0. `adc_rd_o` is high only during bit time 10, so the bus has been released for at least one clock before the read.
- R7: The bus value present during the read clock of slot n is sent on `sd_o` in slot n+1, MSB first: bit k is sent during bit time k.
- R8: In the first slot after synchronisation, `sd_o` sends all zeros.
- R9: Once synchronised, one ADC read occurs in every slot, including the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial bit clock; also the block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_i | input | 1 | Frame sync, high in the clock before bit 15 |
| sd_i | input | 1 | Serial data from the host (DAC words) |
| sd_o | output | 1 | Serial data to the host (ADC results) |
| bus_d_i | input | 16 | Value sampled from the shared parallel bus |
| bus_d_o | output | 16 | Value driven onto the shared parallel bus |
| bus_oe_o | output | 1 | Bus direction: 1 drives the bus, 0 leaves it as input |
| dac_wr_o | output | 1 | DAC write strobe |
| adc_rd_o | output | 1 | ADC read strobe |

## Verification
The bench sweeps all-ones, all-zeros, alternating and walking-bit words in both directions, followed by hashed words. This exposes swapped bit order and misplaced DAC fields; a design that kept the two low serial bits would put the wrong code on the bus.

The bench also covers the following edge cases, each of which catches a specific class of bug:
- **Timing of the first slot.** An early write would show stale data. A missing zero slot would shift every ADC result by a slot.
- **Slots with no sync pulse.** A counter that depends on `fs_i` would stall.
- **Reset in the middle of a run, followed by resynchronisation.** This catches hold or capture state that survives reset.
- **Strobe and drive windows, checked every clock.** A collision or a missing turnaround on the shared bus shows up at the exact cycle.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_READ  = 2'd2
  } bus_phase_e;

  // bit set for every slot index in [lo, hi]
  function automatic logic [31:0] slot_mask(int hi, int lo);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i <= hi && i >= lo) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ssb_frame_ctr.sv
module ssb_frame_ctr #(
  parameter int SLOT_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_i,
  output logic             synced_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o,
  output logic             boundary_o
);

  assign frame_end_o = synced_o && (cnt_o == '0);
  assign boundary_o  = fs_i || frame_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_o <= 1'b0;
      cnt_o    <= '0;
    end else if (boundary_o) begin
      synced_o <= 1'b1;
      cnt_o    <= CNT_W'(SLOT_W - 1);
    end else if (synced_o) begin
      cnt_o    <= cnt_o - 1'b1;
    end
  end

endmodule

// File: rtl/ssb_rx.sv
module ssb_rx #(
  parameter int SLOT_W = 16,
  parameter int DAC_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sd_i,
  input  logic             load_i,
  output logic [DAC_W-1:0] hold_o,
  output logic             hold_vld_o
);

  logic [SLOT_W-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      hold_o     <= '0;
      hold_vld_o <= 1'b0;
    end else begin
      sr_q <= {sr_q[SLOT_W-3:0], sd_i};
      if (load_i) begin
        // sr_q holds bits 15..1 here; keep the top DAC_W of them
        hold_o     <= sr_q[SLOT_W-2 -: DAC_W];
        hold_vld_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssb_tx.sv
module ssb_tx #(
  parameter int SLOT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [SLOT_W-1:0] din_i,
  output logic              sd_o
);

  logic [SLOT_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= din_i;
    else if (shift_i) sr_q <= {sr_q[SLOT_W-2:0], 1'b0};
  end

  assign sd_o = sr_q[SLOT_W-1];

endmodule

// File: rtl/ssb_pbus_seq.sv
module ssb_pbus_seq #(
  parameter int SLOT_W    = 16,
  parameter int DAC_W     = 14,
  parameter int CNT_W     = 4,
  parameter int DRV_FIRST = 15,
  parameter int DRV_LAST  = 13,
  parameter int WR_SLOT   = 14,
  parameter int RD_SLOT   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              synced_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_vld_i,
  input  logic [DAC_W-1:0]  hold_i,
  input  logic [SLOT_W-1:0] bus_d_i,
  output logic [SLOT_W-1:0] bus_d_o,
  output logic              bus_oe_o,
  output logic              dac_wr_o,
  output logic              adc_rd_o,
  output logic [SLOT_W-1:0] adc_cap_o
);
  import ssb_pkg::*;

  localparam logic [31:0] DRV_MASK = slot_mask(DRV_FIRST, DRV_LAST);

  bus_phase_e ph;

  always_comb begin
    ph = PH_IDLE;
    if (synced_i) begin
      if (wr_vld_i && DRV_MASK[cnt_i])        ph = PH_DRIVE;
      else if (cnt_i == CNT_W'(RD_SLOT))       ph = PH_READ;
    end
  end

  assign bus_oe_o = (ph == PH_DRIVE);
  assign dac_wr_o = bus_oe_o && (cnt_i == CNT_W'(WR_SLOT));
  assign adc_rd_o = (ph == PH_READ);
  assign bus_d_o  = bus_oe_o ? SLOT_W'(hold_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       adc_cap_o <= '0;
    else if (adc_rd_o) adc_cap_o <= bus_d_i;
  end

  // R6
  turnaround_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_rd_o |-> (!bus_oe_o && !$past(bus_oe_o)));

  // R5
  wr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_wr_o |-> $past(bus_oe_o));

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_wr_o |=> bus_oe_o);

  // R9
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_rd_o |=> !adc_rd_o);

endmodule

// File: rtl/ssp_pbus_bridge.sv
module ssp_pbus_bridge #(
  parameter int SLOT_W    = 16,
  parameter int DAC_W     = 14,
  parameter int DRV_FIRST = 15,
  parameter int DRV_LAST  = 13,
  parameter int WR_SLOT   = 14,
  parameter int RD_SLOT   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic [SLOT_W-1:0] bus_d_i,
  output logic [SLOT_W-1:0] bus_d_o,
  output logic              bus_oe_o,
  output logic              dac_wr_o,
  output logic              adc_rd_o
);

  localparam int CNT_W = $clog2(SLOT_W);

  logic             synced, frame_end, boundary, hold_vld;
  logic [CNT_W-1:0] cnt;
  logic [DAC_W-1:0] hold;
  logic [SLOT_W-1:0] adc_cap;

  ssb_frame_ctr #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .fs_i,
    .synced_o(synced), .cnt_o(cnt), .frame_end_o(frame_end), .boundary_o(boundary)
  );

  ssb_rx #(.SLOT_W(SLOT_W), .DAC_W(DAC_W)) u_rx (
    .clk_i, .rst_ni, .sd_i,
    .load_i(frame_end), .hold_o(hold), .hold_vld_o(hold_vld)
  );

  ssb_tx #(.SLOT_W(SLOT_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i(boundary), .shift_i(synced), .din_i(adc_cap), .sd_o
  );

  ssb_pbus_seq #(
    .SLOT_W(SLOT_W), .DAC_W(DAC_W), .CNT_W(CNT_W),
    .DRV_FIRST(DRV_FIRST), .DRV_LAST(DRV_LAST),
    .WR_SLOT(WR_SLOT), .RD_SLOT(RD_SLOT)
  ) u_seq (
    .clk_i, .rst_ni,
    .synced_i(synced), .cnt_i(cnt), .wr_vld_i(hold_vld), .hold_i(hold),
    .bus_d_i, .bus_d_o, .bus_oe_o, .dac_wr_o, .adc_rd_o, .adc_cap_o(adc_cap)
  );

  // R2
  quiet_before_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced |-> (!sd_o && !bus_oe_o && !dac_wr_o && !adc_rd_o));

  // R7
  tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (sd_o == $past(adc_cap[SLOT_W-1])));

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_wr_o |-> $stable(hold));

  // R3
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (synced && cnt == CNT_W'(SLOT_W - 1)));

endmodule

// File: tb/ssp_pbus_bridge_tb_top.sv
module ssp_pbus_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NFR        = 40;

  logic        clk = 1'b0, rst_ni = 1'b0, fs_i = 1'b0, sd_i = 1'b0;
  logic [15:0] bus_d_i = '0;
  logic        sd_o, bus_oe_o, dac_wr_o, adc_rd_o;
  logic [15:0] bus_d_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_pbus_bridge dut_i (
    .clk_i(clk), .rst_ni, .fs_i, .sd_i, .sd_o,
    .bus_d_i, .bus_d_o, .bus_oe_o, .dac_wr_o, .adc_rd_o
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] dac_word(int s, int f);
    logic [31:0] h;
    h = (f * 32'h9E37) ^ (s * 32'h3C5A) ^ (f << 5) ^ 32'h1234;
    if (f == 0)      return 16'hFFFF;
    else if (f == 1) return 16'h0000;
    else if (f == 2) return 16'hAAAA;
    else if (f == 3) return 16'h5555;
    else if (f < 20) return 16'(1) << (f - 4);
    else             return h[15:0];
  endfunction

  function automatic logic [15:0] adc_word(int s, int f);
    logic [31:0] h;
    h = (f * 32'h7F4A) ^ (s * 32'hC3B1) ^ (f << 9) ^ 32'h0F0F;
    if (f == 0)      return 16'h8001;
    else if (f == 1) return 16'hFFFF;
    else if (f == 2) return 16'h0000;
    else if (f == 3) return 16'h5555;
    else if (f < 20) return ~(16'(1) << (f - 4));
    else             return h[15:0];
  endfunction

  task automatic chk_quiet(string req);
    chk(sd_o == 1'b0,     req, "sd_o",     32'(sd_o),     0);
    chk(bus_oe_o == 1'b0, req, "bus_oe_o", 32'(bus_oe_o), 0);
    chk(dac_wr_o == 1'b0, req, "dac_wr_o", 32'(dac_wr_o), 0);
    chk(adc_rd_o == 1'b0, req, "adc_rd_o", 32'(adc_rd_o), 0);
    chk(bus_d_o == '0,    req, "bus_d_o",  32'(bus_d_o),  0);
  endtask

  task automatic sweep(int s);
    // R2: activity on the inputs before the first sync pulse
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk_quiet("R2");
      fs_i    = 1'b0;
      sd_i    = i[0];
      bus_d_i = 16'hBEEF ^ 16'(i);
    end
    @(negedge clk);
    chk_quiet("R2");
    fs_i = 1'b1; sd_i = 1'b0;
    for (int f = 0; f < NFR; f++) begin
      for (int k = 15; k >= 0; k--) begin
        logic        e_sd, e_oe, e_wr, e_rd;
        logic [15:0] e_bus;
        logic [15:0] prev_dac;
        @(negedge clk);
        prev_dac = (f > 0) ? dac_word(s, f - 1) : 16'h0;
        e_sd  = (f == 0) ? 1'b0 : adc_word(s, f - 1)[k];
        e_oe  = (f > 0) && (k >= 13);
        e_wr  = (f > 0) && (k == 14);
        e_rd  = (k == 10);
        e_bus = e_oe ? {2'b00, prev_dac[15:2]} : 16'h0;
        chk(sd_o == e_sd, (f == 0) ? "R8" : "R7", "sd_o", 32'(sd_o), 32'(e_sd));
        chk(bus_oe_o == e_oe, "R5", "bus_oe_o", 32'(bus_oe_o), 32'(e_oe));
        chk(dac_wr_o == e_wr, "R5", "dac_wr_o", 32'(dac_wr_o), 32'(e_wr));
        // R3: frames after a missing sync pulse must still read at bit 10
        chk(adc_rd_o == e_rd, (f % 3 == 2) ? "R3" : "R9", "adc_rd_o",
            32'(adc_rd_o), 32'(e_rd));
        chk(bus_d_o == e_bus, e_oe ? "R4" : "R6", "bus_d_o", 32'(bus_d_o), 32'(e_bus));
        fs_i    = (k == 0) && (f % 3 != 1);
        sd_i    = dac_word(s, f)[k];
        bus_d_i = adc_word(s, f);
      end
    end
  endtask

  initial begin
    // R1: outputs while reset is held
    repeat (3) begin
      @(negedge clk);
      chk_quiet("R1");
    end
    rst_ni = 1'b1;
    sweep(1);
    // R1: reset mid-run clears state; next sweep starts from scratch
    @(negedge clk);
    rst_ni = 1'b0; fs_i = 1'b0;
    #1;
    chk_quiet("R1");
    repeat (2) begin
      @(negedge clk);
      chk_quiet("R1");
    end
    rst_ni = 1'b1;
    sweep(2);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule